// File: doc/BRIEF.md
# Operand Forwarding and Address-Interlock Unit

This unit watches the instructions in a seven-stage in-order pipeline: fetch, decode, register read, address generation, data-cache load, ALU, writeback. The unit chooses where each operand of the address-generation stage and each operand of the ALU stage comes from. It also holds the front end when a needed value cannot be produced in time. Results are written by two ports. The address port updates pointers early, in the address-generation stage, for post-increment, pre-decrement and immediate add or subtract on an address register. The ALU port writes late, in the ALU stage.

Each cycle the front end presents a descriptor for the instruction in register read. The descriptor holds a valid bit, up to two address-side sources, up to two ALU-side sources, and one optional destination for each write port. The unit carries the descriptor down its own copy of the later stages.

Most dependences are covered by forwarding. The one exception is an ALU result that one of the next two instructions needs to form an address. In that case the unit raises `stall_o`: the fetch, decode and register-read stages hold, and an empty slot enters address generation. The datapath is assumed to follow two rules. Address-side operands are read from the register file in register read. ALU-side operands are read in the data-cache stage. The register file writes through in writeback.

Top module: `fwd_interlock`

## Requirements
- R1: After reset, `stall_o` and `bubble_o` are low and every forwarding select is 0 (register file).
- R2: Each select is 3 bits, with operand n at bits [3n+2:3n]. The codes are 0 register file, 1 address-port result of the data-cache stage, 2 address-port result of the ALU stage, 3 address-port result of writeback, 4 ALU-port result of writeback. Address-port results reach an address-side consumer from the data-cache, ALU and writeback stages, so back-to-back pointer updates never stall.
- R3: An ALU-side operand produced by the ALU port of the instruction just ahead gets code 4, and a chain of dependent ALU operations issues one per cycle without a stall.
- R4: An ALU-side operand produced by the address port of the instruction just ahead gets code 3.
- R5: When an address-side source is written by the ALU port of the instruction directly ahead, the unit stalls for exactly 2 cycles. The consumer then takes code 4.
- R6: With one unrelated instruction between that producer and the consumer, the stall lasts exactly 1 cycle, and the consumer then takes code 4.
- R7: With two unrelated instructions in between, there is no stall and the code is 4. With three in between, there is no stall and the code is 0.
- R8: When several older in-flight instructions write the same register, the youngest of them supplies the operand.
- R9: A younger address-port write to a register hides an older pending ALU-port write to the same register. No stall results, and the address-port result is forwarded. When the ALU-port write is the younger one, the unit stalls.
- R10: A descriptor with valid=0 neither stalls nor forwards. Its fields do not trigger a stall while it sits in register read, its selects are 0, and its destinations are never matched.
- R11: `bubble_o` equals `stall_o`. In each stalled cycle an empty slot enters address generation while the held instruction waits, so the producers ahead keep moving.
- R12: A source whose register no in-flight producer writes gets code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rr_vld_i | input | 1 | Register-read stage holds an instruction |
| rr_ag_src_vld_i | input | 2 | Address-side source enables |
| rr_ag_src_id_i | input | 8 | Address-side source register IDs, 4 bits each |
| rr_al_src_vld_i | input | 2 | ALU-side source enables |
| rr_al_src_id_i | input | 8 | ALU-side source register IDs, 4 bits each |
| rr_agw_vld_i | input | 1 | Instruction writes through the address port |
| rr_agw_id_i | input | 4 | Address-port destination register |
| rr_alw_vld_i | input | 1 | Instruction writes through the ALU port |
| rr_alw_id_i | input | 4 | ALU-port destination register |
| stall_o | output | 1 | Hold fetch, decode and register read |
| bubble_o | output | 1 | Empty slot enters address generation |
| ag_fwd_sel_o | output | 6 | Operand sources for the address-generation stage |
| al_fwd_sel_o | output | 6 | Operand sources for the ALU stage |

## Verification
A stall and address-side forwarding can fall in the same cycle. The two are tested together by placing a pointer update ahead of an ALU producer, followed by a consumer that needs both registers. After the two-cycle hold, the pointer producer must have retired (code 0) and the ALU value must come from writeback (code 4); a unit that dropped or doubled the bubbles would show code 2 or a different stall count. Stalls and ALU-side forwarding also overlap in time, because the ALU chain keeps flowing while an address consumer waits. Both selects are checked at the cycle the bench computes from the stage count.

// File: rtl/fwd_ilk_pkg.sv
package fwd_ilk_pkg;
  parameter int unsigned REG_W    = 4;
  parameter int unsigned N_AG_SRC = 2;
  parameter int unsigned N_AL_SRC = 2;
  parameter int unsigned SEL_W    = 3;
  // tracked stages after register read: 0 addr-gen, 1 dcache, 2 alu, 3 writeback
  parameter int unsigned N_STG    = 4;
  parameter int unsigned STG_DC   = 1;
  parameter int unsigned STG_AL   = 2;
  parameter int unsigned STG_WB   = 3;

  typedef enum logic [SEL_W-1:0] {
    FS_RF    = 3'd0,
    FS_DC_AG = 3'd1,
    FS_AL_AG = 3'd2,
    FS_WB_AG = 3'd3,
    FS_WB_AL = 3'd4
  } fwd_sel_e;

  typedef struct packed {
    logic             vld;
    logic             gv;
    logic [REG_W-1:0] gid;
    logic             lv;
    logic [REG_W-1:0] lid;
  } wr_t;

  typedef struct packed {
    logic [N_AG_SRC-1:0]            v;
    logic [N_AG_SRC-1:0][REG_W-1:0] id;
  } ag_rd_t;

  typedef struct packed {
    logic [N_AL_SRC-1:0]            v;
    logic [N_AL_SRC-1:0][REG_W-1:0] id;
  } al_rd_t;

  function automatic logic hit_ag(wr_t w, logic [REG_W-1:0] id);
    return w.vld && w.gv && (w.gid == id);
  endfunction

  function automatic logic hit_al(wr_t w, logic [REG_W-1:0] id);
    return w.vld && w.lv && (w.lid == id);
  endfunction
endpackage

// File: rtl/fwd_desc_pipe.sv
module fwd_desc_pipe
  import fwd_ilk_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   stall_i,
  input  wr_t    rr_wr_i,
  input  ag_rd_t rr_ag_i,
  input  al_rd_t rr_al_i,
  output wr_t    wr_o [N_STG],
  output ag_rd_t ag_rd_o,
  output al_rd_t al_rd_o
);
  wr_t    wr_q [N_STG];
  ag_rd_t ag_q;
  al_rd_t al_q [STG_AL+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_STG; k++) wr_q[k] <= '0;
      for (int k = 0; k <= STG_AL; k++) al_q[k] <= '0;
      ag_q <= '0;
    end else begin
      // stall: front end holds, empty slot enters addr-gen
      wr_q[0] <= stall_i ? '0 : rr_wr_i;
      ag_q    <= stall_i ? '0 : rr_ag_i;
      al_q[0] <= stall_i ? '0 : rr_al_i;
      for (int k = 1; k < N_STG; k++) wr_q[k] <= wr_q[k-1];
      for (int k = 1; k <= STG_AL; k++) al_q[k] <= al_q[k-1];
    end
  end

  assign wr_o    = wr_q;
  assign ag_rd_o = ag_q;
  assign al_rd_o = al_q[STG_AL];

  AST_BUBBLE_INS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !wr_q[0].vld); // R11
endmodule

// File: rtl/fwd_hazard_det.sv
module fwd_hazard_det
  import fwd_ilk_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rr_vld_i,
  input  ag_rd_t rr_ag_i,
  input  wr_t    ag_wr_i,
  input  wr_t    dc_wr_i,
  output logic   stall_o
);
  logic [N_AG_SRC-1:0] wait_src;

  for (genvar i = 0; i < N_AG_SRC; i++) begin : g_src
    logic [REG_W-1:0] id;
    logic late_ag, late_dc;
    assign id      = rr_ag_i.id[i];
    assign late_ag = hit_al(ag_wr_i, id);
    // a younger addr-port write in addr-gen shadows the dcache-stage ALU write
    assign late_dc = !hit_ag(ag_wr_i, id) && hit_al(dc_wr_i, id);
    assign wait_src[i] = rr_vld_i && rr_ag_i.v[i] && (late_ag || late_dc);
  end

  assign stall_o = |wait_src;

  logic [1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (!stall_o) run_q <= '0;
    else if (run_q != 2'd3) run_q <= run_q + 2'd1;
  end

  AST_STALL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> run_q < 2'd2); // R5
  AST_IDLE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rr_vld_i |-> !stall_o); // R10
endmodule

// File: rtl/fwd_src_sel.sv
module fwd_src_sel
  import fwd_ilk_pkg::*;
#(
  parameter int unsigned N_SRC  = 2,
  parameter int unsigned N_PROD = 3,
  parameter int unsigned BASE   = 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cons_vld_i,
  input  logic [N_SRC-1:0]             src_v_i,
  input  logic [N_SRC-1:0][REG_W-1:0]  src_id_i,
  input  wr_t                          prod_i [N_PROD],
  output logic [N_SRC*SEL_W-1:0]       sel_o
);
  function automatic fwd_sel_e ag_code(int unsigned s);
    case (s)
      STG_DC:  return FS_DC_AG;
      STG_AL:  return FS_AL_AG;
      default: return FS_WB_AG;
    endcase
  endfunction

  for (genvar i = 0; i < N_SRC; i++) begin : g_op
    fwd_sel_e sel;
    logic     found;
    always_comb begin
      sel   = FS_RF;
      found = 1'b0;
      // prod_i is ordered youngest first
      for (int p = 0; p < N_PROD; p++) begin
        if (!found && hit_ag(prod_i[p], src_id_i[i])) begin
          sel   = ag_code(BASE + p);
          found = 1'b1;
        end else if (!found && hit_al(prod_i[p], src_id_i[i])) begin
          sel   = (BASE + p == STG_WB) ? FS_WB_AL : FS_RF;
          found = 1'b1;
        end
      end
      if (!cons_vld_i || !src_v_i[i]) sel = FS_RF;
    end
    assign sel_o[i*SEL_W +: SEL_W] = sel;
  end

  AST_IDLE_RF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cons_vld_i |-> sel_o == '0); // R10
endmodule

// File: rtl/fwd_interlock.sv
module fwd_interlock
  import fwd_ilk_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rr_vld_i,
  input  logic [N_AG_SRC-1:0]       rr_ag_src_vld_i,
  input  logic [N_AG_SRC*REG_W-1:0] rr_ag_src_id_i,
  input  logic [N_AL_SRC-1:0]       rr_al_src_vld_i,
  input  logic [N_AL_SRC*REG_W-1:0] rr_al_src_id_i,
  input  logic                      rr_agw_vld_i,
  input  logic [REG_W-1:0]          rr_agw_id_i,
  input  logic                      rr_alw_vld_i,
  input  logic [REG_W-1:0]          rr_alw_id_i,
  output logic                      stall_o,
  output logic                      bubble_o,
  output logic [N_AG_SRC*SEL_W-1:0] ag_fwd_sel_o,
  output logic [N_AL_SRC*SEL_W-1:0] al_fwd_sel_o
);
  localparam int unsigned N_AG_PROD = STG_WB - STG_DC + 1;

  wr_t    rr_wr;
  ag_rd_t rr_ag;
  al_rd_t rr_al;
  wr_t    wr [N_STG];
  ag_rd_t ag_rd;
  al_rd_t al_rd;
  wr_t    ag_prod [N_AG_PROD];
  wr_t    al_prod [1];
  logic   stall;

  assign rr_wr = '{vld: rr_vld_i, gv: rr_agw_vld_i, gid: rr_agw_id_i,
                   lv: rr_alw_vld_i, lid: rr_alw_id_i};
  assign rr_ag = '{v: rr_ag_src_vld_i, id: rr_ag_src_id_i};
  assign rr_al = '{v: rr_al_src_vld_i, id: rr_al_src_id_i};

  fwd_desc_pipe u_pipe (
    .clk_i, .rst_ni, .stall_i(stall),
    .rr_wr_i(rr_wr), .rr_ag_i(rr_ag), .rr_al_i(rr_al),
    .wr_o(wr), .ag_rd_o(ag_rd), .al_rd_o(al_rd)
  );

  fwd_hazard_det u_haz (
    .clk_i, .rst_ni, .rr_vld_i,
    .rr_ag_i(rr_ag), .ag_wr_i(wr[0]), .dc_wr_i(wr[STG_DC]),
    .stall_o(stall)
  );

  for (genvar p = 0; p < N_AG_PROD; p++) begin : g_ag_prod
    assign ag_prod[p] = wr[STG_DC + p];
  end
  assign al_prod[0] = wr[STG_WB];

  fwd_src_sel #(.N_SRC(N_AG_SRC), .N_PROD(N_AG_PROD), .BASE(STG_DC)) u_ag_sel (
    .clk_i, .rst_ni, .cons_vld_i(wr[0].vld),
    .src_v_i(ag_rd.v), .src_id_i(ag_rd.id),
    .prod_i(ag_prod), .sel_o(ag_fwd_sel_o)
  );

  fwd_src_sel #(.N_SRC(N_AL_SRC), .N_PROD(1), .BASE(STG_WB)) u_al_sel (
    .clk_i, .rst_ni, .cons_vld_i(wr[STG_AL].vld),
    .src_v_i(al_rd.v), .src_id_i(al_rd.id),
    .prod_i(al_prod), .sel_o(al_fwd_sel_o)
  );

  assign stall_o  = stall;
  assign bubble_o = stall;

  // an address operand in addr-gen never waits on an unfinished ALU write
  for (genvar i = 0; i < N_AG_SRC; i++) begin : g_chk
    logic pend;
    assign pend = hit_al(wr[STG_DC], ag_rd.id[i]) ||
                  (!hit_ag(wr[STG_DC], ag_rd.id[i]) && hit_al(wr[STG_AL], ag_rd.id[i]));
    AST_ADDR_SRC_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr[0].vld && ag_rd.v[i]) |-> !pend); // R5
  end
endmodule

// File: tb/fwd_interlock_bench.sv
module fwd_interlock_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rr_vld = 1'b0;
  logic [1:0] agv = '0, alv = '0;
  logic [7:0] agid = '0, alid = '0;
  logic       gv = 1'b0, lv = 1'b0;
  logic [3:0] gid = '0, lid = '0;
  logic       stall, bubble;
  logic [5:0] ag_sel, al_sel;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fwd_interlock u_fwd_interlock (
    .clk_i(clk), .rst_ni(rst_n), .rr_vld_i(rr_vld),
    .rr_ag_src_vld_i(agv), .rr_ag_src_id_i(agid),
    .rr_al_src_vld_i(alv), .rr_al_src_id_i(alid),
    .rr_agw_vld_i(gv), .rr_agw_id_i(gid),
    .rr_alw_vld_i(lv), .rr_alw_id_i(lid),
    .stall_o(stall), .bubble_o(bubble),
    .ag_fwd_sel_o(ag_sel), .al_fwd_sel_o(al_sel)
  );

  localparam logic [3:0] D0 = 4'd0, D1 = 4'd1, D5 = 4'd5, A0 = 4'd8, A1 = 4'd9;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // issue one instruction at a negedge; hold it while stalled; return stall count
  task automatic send(input logic v, input logic [1:0] a_v, input logic [7:0] a_id,
                      input logic [1:0] l_v, input logic [7:0] l_id,
                      input logic g_v, input logic [3:0] g_id,
                      input logic w_v, input logic [3:0] w_id, output int nst);
    rr_vld = v; agv = a_v; agid = a_id; alv = l_v; alid = l_id;
    gv = g_v; gid = g_id; lv = w_v; lid = w_id;
    #1;
    nst = 0;
    while (stall) begin
      nst++;
      chk("R11 bubble_o with stall", bubble, 1);
      @(posedge clk); @(negedge clk); #1;
    end
    chk("R11 bubble_o low", bubble, 0);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic nop(input int n);
    int s;
    for (int k = 0; k < n; k++) send(1'b1, 2'b00, 8'h00, 2'b00, 8'h00, 1'b0, 4'h0, 1'b0, 4'h0, s);
  endtask

  task automatic drain();
    int s;
    for (int k = 0; k < 5; k++) send(1'b0, 2'b00, 8'h00, 2'b00, 8'h00, 1'b0, 4'h0, 1'b0, 4'h0, s);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 stall", stall, 0);
    chk("R1 bubble", bubble, 0);
    chk("R1 ag sel", ag_sel, 0);
    chk("R1 al sel", al_sel, 0);
  endtask

  task automatic t_ptr_chain();
    int s;
    drain();
    send(1, 2'b01, {4'h0, A0}, 0, 0, 1, A0, 0, 0, s);
    send(1, 2'b01, {4'h0, A0}, 0, 0, 1, A0, 0, 0, s);
    chk("R2 no stall on pointer chain", s, 0);
    chk("R2 dcache addr-port code", ag_sel[2:0], 1);
    send(1, 2'b01, {4'h0, A0}, 0, 0, 1, A0, 0, 0, s);
    chk("R2 dcache addr-port code 2", ag_sel[2:0], 1);
    drain();
    send(1, 0, 0, 0, 0, 1, A1, 0, 0, s);
    nop(2);
    send(1, 2'b10, {A1, 4'h0}, 0, 0, 0, 0, 0, 0, s);
    chk("R2 writeback addr-port code on operand 1", ag_sel[5:3], 3);
    chk("R12 unused operand 0", ag_sel[2:0], 0);
  endtask

  task automatic t_alu_chain();
    int s;
    drain();
    send(1, 0, 0, 0, 0, 0, 0, 1, D1, s);
    send(1, 0, 0, 2'b01, {4'h0, D1}, 0, 0, 1, D1, s);
    chk("R3 no stall", s, 0);
    send(1, 0, 0, 2'b01, {4'h0, D1}, 0, 0, 1, D1, s);
    chk("R3 no stall 2", s, 0);
    nop(1);
    chk("R3 alu code first", al_sel[2:0], 4);
    nop(1);
    chk("R3 alu code second", al_sel[2:0], 4);
  endtask

  task automatic t_alu_from_addr();
    int s;
    drain();
    send(1, 0, 0, 0, 0, 1, A0, 0, 0, s);
    send(1, 0, 0, 2'b11, {D5, A0}, 0, 0, 0, 0, s);
    nop(2);
    chk("R4 alu gets addr-port result", al_sel[2:0], 3);
    chk("R12 unmatched alu operand", al_sel[5:3], 0);
  endtask

  task automatic t_dist(input int gap, input int exp_st, input int exp_sel, input string req);
    int s;
    drain();
    send(1, 0, 0, 0, 0, 0, 0, 1, D0, s);
    nop(gap);
    send(1, 2'b01, {4'h0, D0}, 0, 0, 0, 0, 0, 0, s);
    chk({req, " stall cycles"}, s, exp_st);
    chk({req, " address operand code"}, ag_sel[2:0], exp_sel);
  endtask

  task automatic t_prio();
    int s;
    drain();
    send(1, 0, 0, 0, 0, 1, A1, 0, 0, s);
    send(1, 0, 0, 0, 0, 1, A1, 0, 0, s);
    send(1, 2'b01, {4'h0, A1}, 0, 0, 0, 0, 0, 0, s);
    chk("R8 youngest from dcache", ag_sel[2:0], 1);
    drain();
    send(1, 0, 0, 0, 0, 1, A1, 0, 0, s);
    send(1, 0, 0, 0, 0, 1, A1, 0, 0, s);
    nop(1);
    send(1, 2'b01, {4'h0, A1}, 0, 0, 0, 0, 0, 0, s);
    chk("R8 youngest from alu stage", ag_sel[2:0], 2);
  endtask

  task automatic t_shadow();
    int s;
    drain();
    send(1, 0, 0, 0, 0, 0, 0, 1, A0, s);
    send(1, 0, 0, 0, 0, 1, A0, 0, 0, s);
    send(1, 2'b01, {4'h0, A0}, 0, 0, 0, 0, 0, 0, s);
    chk("R9 shadowed alu write no stall", s, 0);
    chk("R9 shadowed code", ag_sel[2:0], 1);
    drain();
    send(1, 0, 0, 0, 0, 1, A0, 0, 0, s);
    send(1, 0, 0, 0, 0, 0, 0, 1, A0, s);
    send(1, 2'b01, {4'h0, A0}, 0, 0, 0, 0, 0, 0, s);
    chk("R9 younger alu write stalls", s, 2);
  endtask

  task automatic t_invalid();
    int s;
    drain();
    send(1, 0, 0, 0, 0, 0, 0, 1, D0, s);
    send(0, 2'b01, {4'h0, D0}, 0, 0, 1, A0, 0, 0, s);
    chk("R10 invalid consumer no stall", s, 0);
    chk("R10 invalid consumer code", ag_sel[2:0], 0);
    send(1, 2'b01, {4'h0, A0}, 0, 0, 0, 0, 0, 0, s);
    chk("R10 invalid producer not matched", ag_sel[2:0], 0);
    drain();
    send(0, 0, 0, 0, 0, 0, 0, 1, D0, s);
    send(1, 2'b01, {4'h0, D0}, 0, 0, 0, 0, 0, 0, s);
    chk("R10 invalid alu producer no stall", s, 0);
  endtask

  task automatic t_bubble();
    int s;
    drain();
    send(1, 0, 0, 0, 0, 1, A1, 0, 0, s);
    send(1, 0, 0, 0, 0, 0, 0, 1, D0, s);
    send(1, 2'b11, {A1, D0}, 0, 0, 0, 0, 0, 0, s);
    chk("R11 stall cycles", s, 2);
    chk("R11 alu operand after hold", ag_sel[2:0], 4);
    chk("R11 pointer producer retired", ag_sel[5:3], 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ptr_chain();
    t_alu_chain();
    t_alu_from_addr();
    t_dist(0, 2, 4, "R5");
    t_dist(1, 1, 4, "R6");
    t_dist(2, 0, 4, "R7");
    t_dist(3, 0, 0, "R7");
    t_prio();
    t_shadow();
    t_invalid();
    t_bubble();
    drain();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule